// File: doc/BRIEF.md
# Asynchronous SRAM cycle controller

This block sits between a clocked host and an external asynchronous static RAM of 2048 words by 8 bits. The host offers one word at a time through a request/ready handshake, with an address, write data and a write flag. The controller turns each request into a fixed sequence of chip-enable, output-enable and write-enable strobes, and each strobe phase lasts a set number of clock cycles. Read data comes back on a separate port with a one-cycle valid pulse.

Every interval the memory needs is a module parameter in clock periods, and the block rounds it up to whole cycles. The defaults assume a 10 ns clock. The write sequence puts the address out first and then opens the write-enable pulse. It holds the address until write enable has risen and the write-recovery time has passed. Output enable stays high for the whole write, and the controller drives the data bus only inside the write-enable pulse. Between operations chip enable returns high, which deselects the memory.

Top module: `sram_strobe_ctrl`

## Requirements
- R1: After reset, `ready` is 1, `mem_ce_n`, `mem_oe_n` and `mem_we_n` are all 1, `mem_dq_oe` is 0 and `rvalid` is 0.
- R2: A read drives `mem_ce_n`=0, `mem_oe_n`=0 and `mem_we_n`=1. It returns on `rdata` the byte last written to that address, with `rvalid` high for exactly one cycle.
- R3: Read data is captured at the clock edge T_AA cycles after the strobes fall, and not earlier.
- R4: During a write, `mem_oe_n` stays 1 and `mem_ce_n` stays 0 while `mem_we_n` is 0. The write-enable pulse lasts at least T_WP cycles. The address is stable for at least T_AW cycles before the end of the write, and the data is stable for at least T_DW cycles before it.
- R5: `mem_addr` changes only while `mem_we_n` is 1, and only at least T_WR cycles after `mem_we_n` has risen.
- R6: `mem_dq_oe` is 1 only while `mem_we_n` is 0 and `mem_oe_n` is 1. It turns on only after `mem_oe_n` has been 1 for at least T_OHZ cycles.
- R7: A request is accepted only at a clock edge where `ready` and `req` are both 1. `ready` then stays low for the whole operation: 14 cycles for a read and 10 for a write with the default parameters. A `req` that arrives while `ready` is low has no effect.
- R8: Whenever `ready` is 1, `mem_ce_n` is 1, so chip enable returns high between operations.
- R9: All 11 address bits reach the memory, so addresses 0 and 2047 hold independent data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req | input | 1 | Host request |
| ready | output | 1 | Controller can accept a request |
| wr | input | 1 | 1 = write, 0 = read |
| addr | input | 11 | Host word address |
| wdata | input | 8 | Host write data |
| rdata | output | 8 | Read result |
| rvalid | output | 1 | One-cycle strobe for `rdata` |
| mem_addr | output | 11 | Memory address lines |
| mem_ce_n | output | 1 | Memory chip enable, active low |
| mem_oe_n | output | 1 | Memory output enable, active low |
| mem_we_n | output | 1 | Memory write enable, active low |
| mem_dq_out | output | 8 | Data bus value driven by the controller |
| mem_dq_in | input | 8 | Data bus value from the memory |
| mem_dq_oe | output | 1 | Controller data bus driver enable |

## Verification
Suppose the phase state or the phase counter goes wrong. The first sign at the ports is a strobe that ends too early or too late: a write-enable pulse, address window or data window that is too short is caught when write enable rises, and a bad busy length is caught on the next rise of `ready`. Suppose instead the capture point moves earlier. The memory model returns the inverted byte until the access time has passed, so the scoreboard sees a wrong `rdata` on the same `rvalid` pulse. A driver enable or address change outside its window is reported in the cycle it happens.

// File: rtl/sram_strobe_pkg.sv
package sram_strobe_pkg;

    typedef enum logic [2:0] {
        PH_IDLE,
        PH_WSETUP,
        PH_WPULSE,
        PH_READ,
        PH_RECOVER
    } phase_e;

    function automatic int imax(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/sram_cycle_timer.sv
module sram_cycle_timer #(
    parameter int CNT_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    output logic [CNT_W-1:0] cnt,
    output logic             last
);
    logic [CNT_W-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (load)
            cnt_d = load_val;
        else if (cnt_q != '0)
            cnt_d = cnt_q - 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign cnt  = cnt_q;
    assign last = (cnt_q == CNT_W'(1));
endmodule

// File: rtl/sram_read_latch.sv
module sram_read_latch #(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cap,
    input  logic [DATA_W-1:0] din,
    output logic [DATA_W-1:0] rdata,
    output logic              rvalid
);
    typedef struct packed {
        logic [DATA_W-1:0] data;
        logic              vld;
    } lat_t;

    lat_t lat_d, lat_q;

    always_comb begin
        lat_d     = lat_q;
        lat_d.vld = cap;
        if (cap) lat_d.data = din;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) lat_q <= '0;
        else        lat_q <= lat_d;
    end

    assign rdata  = lat_q.data;
    assign rvalid = lat_q.vld;

    // R2: valid strobe lasts a single cycle
    a_r2_one_cycle_valid: assert property (@(posedge clk) disable iff (!rst_n)
        rvalid |=> !rvalid);
endmodule

// File: rtl/sram_strobe_ctrl.sv
module sram_strobe_ctrl
    import sram_strobe_pkg::*;
#(
    parameter int ADDR_W = 11,
    parameter int DATA_W = 8,
    parameter int T_RC   = 10,
    parameter int T_AA   = 10,
    parameter int T_OE   = 4,
    parameter int T_WC   = 10,
    parameter int T_WP   = 6,
    parameter int T_AW   = 8,
    parameter int T_WR   = 1,
    parameter int T_DW   = 3,
    parameter int T_OHZ  = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req,
    output logic              ready,
    input  logic              wr,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata,
    output logic              rvalid,
    output logic [ADDR_W-1:0] mem_addr,
    output logic              mem_ce_n,
    output logic              mem_oe_n,
    output logic              mem_we_n,
    output logic [DATA_W-1:0] mem_dq_out,
    input  logic [DATA_W-1:0] mem_dq_in,
    output logic              mem_dq_oe
);
    // derived phase lengths in cycles
    localparam int ACC_LEN = imax(T_AA, T_OE);
    localparam int RD_LEN  = imax(T_RC, ACC_LEN);
    localparam int RD_CAP  = RD_LEN - ACC_LEN + 1;
    localparam int RD_REC  = imax(T_OHZ, 1);
    localparam int WP_LEN  = imax(imax(T_WP, T_AW - 1), T_DW);
    localparam int WR_REC  = imax(imax(T_WR, T_WC - 1 - WP_LEN), 1);
    localparam int MAX_LEN = imax(imax(RD_LEN, RD_REC), imax(WP_LEN, WR_REC));
    localparam int CNT_W   = $clog2(MAX_LEN + 1);

    typedef struct packed {
        phase_e            phase;
        logic              ce_n;
        logic              oe_n;
        logic              we_n;
        logic              drv;
        logic [ADDR_W-1:0] addr;
        logic [DATA_W-1:0] wd;
    } ctl_t;

    ctl_t             st_d, st_q;
    logic             tmr_load_d;
    logic [CNT_W-1:0] tmr_val_d;
    logic [CNT_W-1:0] tmr_cnt;
    logic             tmr_last;
    logic             cap_d;

    sram_cycle_timer #(.CNT_W(CNT_W)) u_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (tmr_load_d),
        .load_val (tmr_val_d),
        .cnt      (tmr_cnt),
        .last     (tmr_last)
    );

    always_comb begin
        st_d       = st_q;
        tmr_load_d = 1'b0;
        tmr_val_d  = '0;
        cap_d      = 1'b0;
        unique case (st_q.phase)
            PH_IDLE: begin
                if (req) begin
                    st_d.addr  = addr;
                    st_d.ce_n  = 1'b0;
                    tmr_load_d = 1'b1;
                    if (wr) begin
                        st_d.phase = PH_WSETUP;
                        st_d.wd    = wdata;
                        tmr_val_d  = CNT_W'(1);
                    end else begin
                        st_d.phase = PH_READ;
                        st_d.oe_n  = 1'b0;
                        tmr_val_d  = CNT_W'(RD_LEN);
                    end
                end
            end
            PH_WSETUP: begin
                if (tmr_last) begin
                    st_d.phase = PH_WPULSE;
                    st_d.we_n  = 1'b0;
                    st_d.drv   = 1'b1;
                    tmr_load_d = 1'b1;
                    tmr_val_d  = CNT_W'(WP_LEN);
                end
            end
            PH_WPULSE: begin
                if (tmr_last) begin
                    st_d.phase = PH_RECOVER;
                    st_d.we_n  = 1'b1;
                    st_d.drv   = 1'b0;
                    st_d.ce_n  = 1'b1;
                    tmr_load_d = 1'b1;
                    tmr_val_d  = CNT_W'(WR_REC);
                end
            end
            PH_READ: begin
                cap_d = (tmr_cnt == CNT_W'(RD_CAP));
                if (tmr_last) begin
                    st_d.phase = PH_RECOVER;
                    st_d.ce_n  = 1'b1;
                    st_d.oe_n  = 1'b1;
                    tmr_load_d = 1'b1;
                    tmr_val_d  = CNT_W'(RD_REC);
                end
            end
            PH_RECOVER: begin
                if (tmr_last) st_d.phase = PH_IDLE;
            end
            default: st_d.phase = PH_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q       <= '0;
            st_q.phase <= PH_IDLE;
            st_q.ce_n  <= 1'b1;
            st_q.oe_n  <= 1'b1;
            st_q.we_n  <= 1'b1;
        end else begin
            st_q <= st_d;
        end
    end

    sram_read_latch #(.DATA_W(DATA_W)) u_latch (
        .clk    (clk),
        .rst_n  (rst_n),
        .cap    (cap_d),
        .din    (mem_dq_in),
        .rdata  (rdata),
        .rvalid (rvalid)
    );

    assign ready      = (st_q.phase == PH_IDLE);
    assign mem_addr   = st_q.addr;
    assign mem_ce_n   = st_q.ce_n;
    assign mem_oe_n   = st_q.oe_n;
    assign mem_we_n   = st_q.we_n;
    assign mem_dq_out = st_q.wd;
    assign mem_dq_oe  = st_q.drv;

    // R6: bus driven only inside the write pulse with outputs disabled
    a_r6_drive_window: assert property (@(posedge clk) disable iff (!rst_n)
        mem_dq_oe |-> (mem_oe_n && !mem_we_n));
    // R5: address frozen while write enable is low
    a_r5_addr_frozen: assert property (@(posedge clk) disable iff (!rst_n)
        !mem_we_n |-> $stable(mem_addr));
    // R4: outputs disabled and chip selected throughout the write pulse
    a_r4_oe_high_in_write: assert property (@(posedge clk) disable iff (!rst_n)
        !mem_we_n |-> (mem_oe_n && !mem_ce_n));
    // R8: idle means deselected
    a_r8_idle_deselect: assert property (@(posedge clk) disable iff (!rst_n)
        ready |-> mem_ce_n);
    // R7: an accepted request makes the controller busy
    a_r7_accept_busy: assert property (@(posedge clk) disable iff (!rst_n)
        (ready && req) |=> !ready);
endmodule

// File: tb/sram_strobe_ctrl_tb.sv
module sram_strobe_ctrl_tb;
    localparam int AW = 11;
    localparam int DW = 8;
    localparam int P_AA = 10, P_WP = 6, P_AW = 8, P_WR = 1, P_DW = 3, P_OHZ = 4;
    localparam int BUSY_RD = 14;
    localparam int BUSY_WR = 10;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          req = 1'b0;
    logic          wr = 1'b0;
    logic [AW-1:0] addr = '0;
    logic [DW-1:0] wdata = '0;
    logic          ready, rvalid;
    logic [DW-1:0] rdata;
    logic [AW-1:0] mem_addr;
    logic          mem_ce_n, mem_oe_n, mem_we_n, mem_dq_oe;
    logic [DW-1:0] mem_dq_out, mem_dq_in;

    int checks = 0;
    int errors = 0;
    int writes_seen = 0;
    int writes_sent = 0;

    always #5 clk = ~clk;

    sram_strobe_ctrl u_dut (
        .clk(clk), .rst_n(rst_n), .req(req), .ready(ready), .wr(wr),
        .addr(addr), .wdata(wdata), .rdata(rdata), .rvalid(rvalid),
        .mem_addr(mem_addr), .mem_ce_n(mem_ce_n), .mem_oe_n(mem_oe_n),
        .mem_we_n(mem_we_n), .mem_dq_out(mem_dq_out), .mem_dq_in(mem_dq_in),
        .mem_dq_oe(mem_dq_oe)
    );

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d t=%0t", tag, act, exp, $time);
        end
    endtask

    // ---------------- behavioural memory with timing checks ----------------
    logic [DW-1:0] ram    [2**AW];
    logic [DW-1:0] shadow [2**AW];
    int            rd_cnt = 0, wlo_cnt = 0, aw_cnt = 0, dstab_cnt = 0;
    int            oehi_cnt = 0, since_we_rise = 100;
    logic          p_we_n = 1'b1, p_rd = 1'b0, p_doe = 1'b0;
    logic [AW-1:0] p_addr = '0;
    logic [DW-1:0] p_dq = '0;

    assign mem_dq_in = (rd_cnt >= P_AA) ? ram[mem_addr] : ~ram[mem_addr];

    always @(negedge clk) begin
        logic rd_now;
        rd_now = rst_n && !mem_ce_n && !mem_oe_n && mem_we_n;
        if (rd_now) rd_cnt = (p_rd && mem_addr == p_addr) ? rd_cnt + 1 : 1;
        else        rd_cnt = 0;
        aw_cnt   = (mem_addr == p_addr) ? aw_cnt + 1 : 1;
        oehi_cnt = mem_oe_n ? oehi_cnt + 1 : 0;
        if (rst_n) begin
            if (mem_addr != p_addr) begin
                if (!mem_we_n || !p_we_n)
                    chk(1'b0, "R5 addr moved with we low", mem_addr, p_addr);
                else chk(since_we_rise >= P_WR, "R5 write recovery", since_we_rise, P_WR);
            end
            if (mem_dq_oe && (!mem_oe_n || mem_we_n))
                chk(1'b0, "R6 drive outside window", mem_oe_n, 1);
            if (mem_dq_oe && !p_doe)
                chk(oehi_cnt > P_OHZ, "R6 driver on after oe high", oehi_cnt, P_OHZ + 1);
            if (!mem_we_n) begin
                wlo_cnt++;
                if (mem_ce_n || !mem_oe_n) chk(1'b0, "R4 strobes during write", mem_oe_n, 1);
                dstab_cnt = (mem_dq_oe && mem_dq_out == p_dq && p_doe) ? dstab_cnt + 1 : 1;
            end
            if (mem_we_n && !p_we_n) begin
                chk(wlo_cnt >= P_WP, "R4 write pulse width", wlo_cnt, P_WP);
                chk(aw_cnt - 1 >= P_AW, "R4 address valid to end of write", aw_cnt - 1, P_AW);
                chk(dstab_cnt >= P_DW, "R4 data setup", dstab_cnt, P_DW);
                ram[p_addr] = p_dq;
                writes_seen++;
                wlo_cnt = 0;
                since_we_rise = 0;
            end
            since_we_rise++;
        end
        p_we_n = mem_we_n; p_rd = rd_now; p_addr = mem_addr;
        p_dq = mem_dq_out; p_doe = mem_dq_oe;
    end

    // ---------------- scoreboard ----------------
    logic [DW-1:0] exp_q[$];
    logic          p_rvalid = 1'b0;

    always @(negedge clk) begin
        if (rst_n) begin
            if (p_rvalid) chk(!rvalid, "R2 rvalid one cycle", rvalid, 0);
            if (rvalid) begin
                if (exp_q.size() == 0) chk(1'b0, "R2 unexpected rvalid", 1, 0);
                else begin
                    logic [DW-1:0] e;
                    e = exp_q.pop_front();
                    // R3: early capture yields the inverted byte
                    chk(rdata == e, "R2 R3 read data", rdata, e);
                end
            end
            p_rvalid = rvalid;
        end
    end

    task automatic do_op(input bit w, input logic [AW-1:0] a, input logic [DW-1:0] d,
                         input bit poke);
        int n;
        @(negedge clk);
        while (!ready) @(negedge clk);
        req = 1'b1; wr = w; addr = a; wdata = d;
        if (w) begin shadow[a] = d; writes_sent++; end
        else exp_q.push_back(shadow[a]);
        @(negedge clk);
        req = 1'b0;
        n = 0;
        while (!ready) begin
            n++;
            if (poke && n == 2) begin
                req = 1'b1; wr = 1'b1; addr = a + 1'b1; wdata = ~d;
            end
            if (poke && n == 5) req = 1'b0;
            @(negedge clk);
        end
        chk(n == (w ? BUSY_WR : BUSY_RD), "R7 busy length", n, w ? BUSY_WR : BUSY_RD);
        chk(mem_ce_n == 1'b1, "R8 deselect between ops", mem_ce_n, 1);
    endtask

    initial begin
        for (int i = 0; i < 2**AW; i++) begin
            ram[i]    = DW'(i ^ 8'h5A);
            shadow[i] = DW'(i ^ 8'h5A);
        end
        repeat (3) @(negedge clk);
        chk(ready && mem_ce_n && mem_oe_n && mem_we_n && !mem_dq_oe && !rvalid,
            "R1 reset state", {ready, mem_ce_n, mem_oe_n, mem_we_n, mem_dq_oe, rvalid}, 6'b111100);
        rst_n = 1'b1;
        @(negedge clk);
        chk(ready && mem_ce_n && !rvalid, "R1 after release", ready, 1);

        // R2 R4 basic write then read
        do_op(1'b1, 11'd5, 8'hA5, 1'b0);
        do_op(1'b0, 11'd5, 8'h00, 1'b0);
        // R9 address extremes
        do_op(1'b1, 11'd0, 8'h11, 1'b0);
        do_op(1'b1, 11'd2047, 8'h22, 1'b0);
        do_op(1'b0, 11'd0, 8'h00, 1'b0);
        do_op(1'b0, 11'd2047, 8'h00, 1'b0);
        // R3 unwritten location returns its initial content
        do_op(1'b0, 11'd1024, 8'h00, 1'b0);
        // R7 request while busy is ignored
        do_op(1'b1, 11'd100, 8'h33, 1'b1);
        do_op(1'b0, 11'd101, 8'h00, 1'b0);
        do_op(1'b0, 11'd100, 8'h00, 1'b0);
        // mixed back-to-back traffic
        for (int k = 0; k < 24; k++) begin
            logic [AW-1:0] a;
            a = AW'(k * 173 + 7);
            do_op(1'b1, a, DW'(k * 37 + 1), 1'b0);
            if (k % 3 == 0) do_op(1'b1, a + 1'b1, DW'(k), 1'b0);
            do_op(1'b0, a, 8'h00, 1'b0);
        end
        repeat (20) @(negedge clk);
        chk(exp_q.size() == 0, "R2 all reads returned", exp_q.size(), 0);
        chk(writes_seen == writes_sent, "R4 writes reached memory", writes_seen, writes_sent);
        chk(ram[2047] == 8'h22 && ram[0] == 8'h11, "R9 extreme addresses in memory",
            ram[2047], 8'h22);
        chk(ram[101] == DW'(101 ^ 8'h5A), "R7 poked address untouched", ram[101], 101 ^ 8'h5A);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule